// File: doc/BRIEF.md
# Prioritized Interrupt Request Logic

This block gathers interrupt sources into one pending-status field and turns it into a single interrupt request for a processor core. The field holds two kinds of bits. The lowest bits are software interrupts, set and cleared only through their own write port. The upper bits follow hardware interrupt lines, and each line reports its level through an update port that carries a line index and a level. A local-enable field, loaded through a separate write port, masks the status field. The result is the effective pending set.

The request is raised when the effective pending set is non-empty, the global interrupt enable is high and the core is not in debug mode. Alongside the request the block gives the index of the highest-numbered effective pending bit, registered together with a valid flag. That index stays frozen while the request is high, so the exception-entry logic always samples a consistent vector. A wake output tells a halted core that an enabled interrupt is pending. It looks at neither the global enable nor debug mode. The status and enable fields are also driven out as plain outputs. There is no streaming data path, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `irq_req_ctrl`

## Requirements
- R1: A write on the level port with an index from 2 to 12 copies the level into the status bit of that index. Level 1 sets the bit and level 0 clears it. The new value appears on `pend_o` one clock later.
- R2: A level-port write whose index is 0, 1 or 13 to 31 changes no status bit.
- R3: Status bits 0 and 1 take `sw_wdata_i[0]` and `sw_wdata_i[1]` on a software write, and change at no other time.
- R4: The effective pending set is `pend_o & en_o`. `irq_req_o` goes high one clock after the set is non-empty while `gie_i` is 1 and `dbg_i` is 0. Otherwise it is low one clock later.
- R5: When the request is low, `vec_o` takes the index of the highest-numbered set bit in the effective pending set one clock later. `vec_valid_o` shows whether the set was non-empty. An empty set gives `vec_o` = 0 and `vec_valid_o` = 0.
- R6: While `irq_req_o` is high, `vec_o` and `vec_valid_o` hold their values, even if a higher-numbered line becomes pending. They refresh one clock after the request falls.
- R7: `wake_o` is high one clock after the effective pending set is non-empty, and low one clock after it is empty, whatever `gie_i` and `dbg_i` are.
- R8: After reset the status bits, the enable bits, `irq_req_o`, `vec_valid_o`, `vec_o` and `wake_o` are all 0.
- R9: An enable write replaces all 13 enable bits with `en_wdata_i`, visible on `en_o` one clock later. Without a write the enable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_we_i | input | 1 | Level update strobe for one hardware line |
| lvl_idx_i | input | 5 | Index of the line being updated |
| lvl_val_i | input | 1 | New level of that line |
| sw_we_i | input | 1 | Software-interrupt bit write strobe |
| sw_wdata_i | input | 2 | New software-interrupt bits |
| en_we_i | input | 1 | Local-enable write strobe |
| en_wdata_i | input | 13 | New local-enable field |
| gie_i | input | 1 | Global interrupt enable |
| dbg_i | input | 1 | Core is in debug mode |
| irq_req_o | output | 1 | Interrupt request to the core |
| vec_valid_o | output | 1 | `vec_o` names a pending line |
| vec_o | output | 4 | Index of the winning line |
| wake_o | output | 1 | Wake indication for a halted core |
| pend_o | output | 13 | Pending-status field |
| en_o | output | 13 | Local-enable field |

## Verification
The hardest case to reach from the ports is the vector freeze. A higher-numbered line must become pending while the request is already high, and the held index must then give way on the cycle after the request falls. The stimulus builds a request on a low line and raises a higher line a few cycles later. It checks that the old index survives, then drops the global enable and samples the vector on each of the next two cycles. The table walk clears the enable field between entries so that no freeze carries over from one entry to the next.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
  localparam int unsigned IRQ_BITS_DEF = 13;
  localparam int unsigned IRQ_SW_DEF   = 2;
  localparam int unsigned IRQ_IDX_DEF  = 5;

  typedef struct packed {
    logic       req;
    logic       wake;
    logic       valid;
  } irq_flags_t;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned NUM_BITS = irq_req_pkg::IRQ_BITS_DEF,
  parameter int unsigned SW_BITS  = irq_req_pkg::IRQ_SW_DEF,
  parameter int unsigned IDX_W    = irq_req_pkg::IRQ_IDX_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lvl_we_i,
  input  logic [IDX_W-1:0]    lvl_idx_i,
  input  logic                lvl_val_i,
  input  logic                sw_we_i,
  input  logic [SW_BITS-1:0]  sw_wdata_i,
  output logic [NUM_BITS-1:0] stat_o
);
  logic [NUM_BITS-1:0] stat_q;
  logic                idx_bad;

  assign idx_bad = (lvl_idx_i >= IDX_W'(NUM_BITS)) || (lvl_idx_i < IDX_W'(SW_BITS));

  for (genvar g = 0; g < NUM_BITS; g++) begin : g_bit
    if (g < SW_BITS) begin : g_sw
      always_ff @(posedge clk) begin
        if (!rst_n)       stat_q[g] <= 1'b0;
        else if (sw_we_i) stat_q[g] <= sw_wdata_i[g];
      end

      assert_sw_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we_i |=> $stable(stat_q[g]));
    end else begin : g_hw
      logic hit;
      assign hit = lvl_we_i && (lvl_idx_i == IDX_W'(g));

      always_ff @(posedge clk) begin
        if (!rst_n)   stat_q[g] <= 1'b0;
        else if (hit) stat_q[g] <= lvl_val_i;
      end

      assert_level_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_we_i && lvl_idx_i == IDX_W'(g)) |=> (stat_q[g] == $past(lvl_val_i)));
    end
  end

  assert_bad_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_we_i && idx_bad && !sw_we_i) |=> $stable(stat_q));

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned NUM_BITS = irq_req_pkg::IRQ_BITS_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_we_i,
  input  logic [NUM_BITS-1:0] en_wdata_i,
  output logic [NUM_BITS-1:0] en_o
);
  logic [NUM_BITS-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assert_en_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_we_i |=> (en_q == $past(en_wdata_i)));
  assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we_i |=> $stable(en_q));

  assign en_o = en_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_BITS = irq_req_pkg::IRQ_BITS_DEF,
  localparam int unsigned VEC_W   = $clog2(NUM_BITS)
) (
  input  logic [NUM_BITS-1:0] eff_i,
  output logic                any_o,
  output logic [VEC_W-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_BITS; i++) begin
      if (eff_i[i]) idx_o = VEC_W'(i);
    end
  end

  assign any_o = |eff_i;

  always_comb begin
    if (any_o) begin
      assert_top_wins_R5: assert ((eff_i >> idx_o) == NUM_BITS'(1));
    end
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int unsigned NUM_BITS = irq_req_pkg::IRQ_BITS_DEF,
  localparam int unsigned VEC_W   = $clog2(NUM_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [VEC_W-1:0] idx_i,
  input  logic             gie_i,
  input  logic             dbg_i,
  output logic             req_o,
  output logic             wake_o,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o
);
  import irq_req_pkg::*;

  irq_flags_t       flg_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q <= '0;
      vec_q <= '0;
    end else begin
      flg_q.req  <= any_i && gie_i && !dbg_i;
      flg_q.wake <= any_i;
      if (!flg_q.req) begin
        flg_q.valid <= any_i;
        vec_q       <= idx_i;
      end
    end
  end

  assert_req_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flg_q.req |-> $past(gie_i && !dbg_i));
  assert_vec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flg_q.req |=> ($stable(vec_q) && $stable(flg_q.valid)));
  assert_wake_with_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q.req) |-> flg_q.wake);

  assign req_o   = flg_q.req;
  assign wake_o  = flg_q.wake;
  assign valid_o = flg_q.valid;
  assign vec_o   = vec_q;
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl #(
  parameter int unsigned NUM_BITS = irq_req_pkg::IRQ_BITS_DEF,
  parameter int unsigned SW_BITS  = irq_req_pkg::IRQ_SW_DEF,
  parameter int unsigned IDX_W    = irq_req_pkg::IRQ_IDX_DEF,
  localparam int unsigned VEC_W   = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lvl_we_i,
  input  logic [IDX_W-1:0]    lvl_idx_i,
  input  logic                lvl_val_i,
  input  logic                sw_we_i,
  input  logic [SW_BITS-1:0]  sw_wdata_i,
  input  logic                en_we_i,
  input  logic [NUM_BITS-1:0] en_wdata_i,
  input  logic                gie_i,
  input  logic                dbg_i,
  output logic                irq_req_o,
  output logic                vec_valid_o,
  output logic [VEC_W-1:0]    vec_o,
  output logic                wake_o,
  output logic [NUM_BITS-1:0] pend_o,
  output logic [NUM_BITS-1:0] en_o
);
  logic [NUM_BITS-1:0] stat_w;
  logic [NUM_BITS-1:0] en_w;
  logic [NUM_BITS-1:0] eff_w;
  logic                any_w;
  logic [VEC_W-1:0]    idx_w;

  irq_status_reg #(.NUM_BITS(NUM_BITS), .SW_BITS(SW_BITS), .IDX_W(IDX_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_we_i   (lvl_we_i),
    .lvl_idx_i  (lvl_idx_i),
    .lvl_val_i  (lvl_val_i),
    .sw_we_i    (sw_we_i),
    .sw_wdata_i (sw_wdata_i),
    .stat_o     (stat_w)
  );

  irq_enable_reg #(.NUM_BITS(NUM_BITS)) u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .en_o       (en_w)
  );

  assign eff_w = stat_w & en_w;

  irq_prio_enc #(.NUM_BITS(NUM_BITS)) u_enc (
    .eff_i (eff_w),
    .any_o (any_w),
    .idx_o (idx_w)
  );

  irq_req_gen #(.NUM_BITS(NUM_BITS)) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_i   (any_w),
    .idx_i   (idx_w),
    .gie_i   (gie_i),
    .dbg_i   (dbg_i),
    .req_o   (irq_req_o),
    .wake_o  (wake_o),
    .valid_o (vec_valid_o),
    .vec_o   (vec_o)
  );

  assign pend_o = stat_w;
  assign en_o   = en_w;
endmodule

// File: tb/irq_req_ctrl_tb.sv
`timescale 1ns/1ps
module irq_req_ctrl_tb_top;
  localparam int N = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lvl_we = 1'b0;
  logic [4:0]    lvl_idx = '0;
  logic          lvl_val = 1'b0;
  logic          sw_we = 1'b0;
  logic [1:0]    sw_wdata = '0;
  logic          en_we = 1'b0;
  logic [N-1:0]  en_wdata = '0;
  logic          gie = 1'b0;
  logic          dbg = 1'b0;
  logic          irq_req, vec_valid, wake;
  logic [3:0]    vec;
  logic [N-1:0]  pend, en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_req_ctrl dut_i (
    .clk (clk), .rst_n (rst_n),
    .lvl_we_i (lvl_we), .lvl_idx_i (lvl_idx), .lvl_val_i (lvl_val),
    .sw_we_i (sw_we), .sw_wdata_i (sw_wdata),
    .en_we_i (en_we), .en_wdata_i (en_wdata),
    .gie_i (gie), .dbg_i (dbg),
    .irq_req_o (irq_req), .vec_valid_o (vec_valid), .vec_o (vec),
    .wake_o (wake), .pend_o (pend), .en_o (en)
  );

  // {status, enable, gie, dbg, req, wake, valid, vec}
  localparam logic [34:0] TBL [10] = '{
    {13'h0004, 13'h1FFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2},
    {13'h1004, 13'h1FFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd12},
    {13'h1004, 13'h0FFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2},
    {13'h0003, 13'h0003, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1},
    {13'h0FF0, 13'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0},
    {13'h0120, 13'h01FF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},
    {13'h0120, 13'h01FF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd8},
    {13'h0001, 13'h1FFE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0},
    {13'h0842, 13'h0FFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd11},
    {13'h0000, 13'h1FFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic lvl_wr(input int idx, input logic v);
    lvl_we = 1'b1; lvl_idx = 5'(idx); lvl_val = v;
    @(negedge clk);
    lvl_we = 1'b0;
  endtask

  task automatic sw_wr(input logic [1:0] v);
    sw_we = 1'b1; sw_wdata = v;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic en_wr(input logic [N-1:0] v);
    en_we = 1'b1; en_wdata = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic set_stat(input logic [N-1:0] v);
    for (int i = 2; i < N; i++) lvl_wr(i, v[i]);
    sw_wr(v[1:0]);
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " R8 pend"}, 32'(pend), 0);
    chk({tag, " R8 en"}, 32'(en), 0);
    chk({tag, " R8 req"}, 32'(irq_req), 0);
    chk({tag, " R8 valid"}, 32'(vec_valid), 0);
    chk({tag, " R8 vec"}, 32'(vec), 0);
    chk({tag, " R8 wake"}, 32'(wake), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check_reset_state("initial");

    // table walk: R1 R3 R4 R5 R7 R9
    for (int t = 0; t < 10; t++) begin
      logic [34:0] e;
      e = TBL[t];
      gie = 1'b0; dbg = 1'b0;
      en_wr('0);
      cyc(2);
      set_stat(e[34:22]);
      en_wr(e[21:9]);
      gie = e[8]; dbg = e[7];
      cyc(3);
      chk("R1 R3 pend", 32'(pend), 32'(e[34:22]));
      chk("R9 en", 32'(en), 32'(e[21:9]));
      chk("R4 req", 32'(irq_req), 32'(e[6]));
      chk("R7 wake", 32'(wake), 32'(e[5]));
      chk("R5 valid", 32'(vec_valid), 32'(e[4]));
      chk("R5 vec", 32'(vec), 32'(e[3:0]));
    end

    // R2: out-of-range and software indices on the level port
    gie = 1'b0; dbg = 1'b0;
    set_stat(13'h0006);
    lvl_wr(13, 1'b1);
    lvl_wr(31, 1'b1);
    lvl_wr(0, 1'b1);
    lvl_wr(1, 1'b0);
    cyc(1);
    chk("R2 bad index ignored", 32'(pend), 32'h0006);
    // R3: software bits change only through their port
    sw_wr(2'b01);
    chk("R3 sw write", 32'(pend), 32'h0005);
    // R1: deassert clears a line
    lvl_wr(2, 1'b0);
    chk("R1 level clear", 32'(pend), 32'h0001);

    // R6: vector freeze while request high
    sw_wr(2'b00);
    en_wr(13'h1FFF);
    lvl_wr(3, 1'b1);
    gie = 1'b1;
    cyc(3);
    chk("R6 start req", 32'(irq_req), 1);
    chk("R6 start vec", 32'(vec), 3);
    lvl_wr(9, 1'b1);
    cyc(3);
    chk("R6 vec held", 32'(vec), 3);
    chk("R6 req still high", 32'(irq_req), 1);
    gie = 1'b0;
    cyc(1);
    chk("R4 req falls", 32'(irq_req), 0);
    chk("R6 vec held on fall edge", 32'(vec), 3);
    cyc(1);
    chk("R6 vec refresh", 32'(vec), 9);
    chk("R7 wake without gie", 32'(wake), 1);

    // R8: reset in the middle of activity
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    check_reset_state("mid-run");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule